// File: doc/BRIEF.md
# Standard-Speed I2C Clock Period Generator

This block produces the master clock waveform for a standard-speed I2C bus. Two 16-bit count registers give the length of the low phase and the high phase of SCL, both measured in reference-clock cycles. A third register holds the on/off control. While the control bit is set, the block drives SCL through an open-drain pin pair. Each period is a low phase followed by a high phase, and the pattern repeats without a break.

Software programs the counts through a plain write strobe with a two-bit address, and reads any register back through a combinational read port. The counts are locked while the generator runs. Software therefore sets them while the generator is off, then switches it on. A write below the legal floor of 8 is raised to 8 silently. A one-cycle strobe marks the start of every low phase, so a data shifter can be attached later.

Top module: `scl_ss_gen`

## Requirements
- R1: After reset, the control register reads 0, the high count reads 16'h0190, the low count reads 16'h0310, and SCL is released (`scl_drive_low_o` = 0).
- R2: Register addresses are 0 for control (bit 0 = run, other bits read 0), 1 for the high count and 2 for the low count. `reg_rdata_o` shows the addressed register in the same cycle.
- R3: A write to address 1 or 2 while the run bit is 1 is dropped, and the stored count is unchanged. The run bit itself stays writable at all times.
- R4: A count write below 8 stores 8. A write of 8 or more stores the written value, and reads return the stored value.
- R5: While running, every low phase lasts exactly the low count in reference-clock cycles.
- R6: While running, every high phase lasts exactly the high count in reference-clock cycles.
- R7: While the run bit is 0, SCL is released and the phase counter is idle. In the first cycle after the run bit is written to 1, a full low phase begins. In the first cycle after it is written to 0, SCL is released.
- R8: `scl_fall_o` is 1 for exactly the first cycle of each low phase and is 0 at all other times.
- R9: Address 3 reads the sampled SCL line in bit 0, after a two-flop synchronizer. A change on `scl_i` is visible on the read port two cycles later. Its value after reset is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for read and write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| scl_i | input | 1 | Sampled SCL line level |
| scl_drive_low_o | output | 1 | Pull SCL low when 1, release when 0 |
| scl_fall_o | output | 1 | One-cycle strobe at the start of each low phase |

## Verification
The embedded assertions check several properties on every cycle:
- Each stored count stays at or above the floor.
- A locked register never changes.
- The phase flag toggles only at the terminal count.
- The counter stays idle while the generator is stopped.
- The falling-edge strobe never lasts two cycles.

Other behaviour needs the bench's directed scenarios:
- The exact low and high run lengths for several programmed pairs, including the minimum.
- The reset values and the clamped readback.
- The low phase starting in the cycle right after the run bit is set.
- The synchronizer latency on the line readback.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned CNT_MIN  = 8;
  localparam logic [CNT_W-1:0] HCNT_RST = 16'h0190;
  localparam logic [CNT_W-1:0] LCNT_RST = 16'h0310;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_HCNT = 2'd1,
    ADDR_LCNT = 2'd2,
    ADDR_LINE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/scl_cnt_reg.sv
module scl_cnt_reg #(
  parameter int unsigned   W   = 16,
  parameter int unsigned   MIN = 8,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         lock_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN);

  logic [W-1:0] q_q;
  logic [W-1:0] clamped;

  assign clamped = (wdata_i < MIN_V) ? MIN_V : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_q <= RST;
    else if (we_i && !lock_i) q_q <= clamped;
  end

  assign q_o = q_q;

  // R3
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(q_q));

  // R4
  floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q >= MIN_V);
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] hcnt_i,
  input  logic [W-1:0] lcnt_i,
  output logic         drive_low_o,
  output logic         fall_o
);
  logic [W-1:0] cnt_q;
  logic         high_q;
  logic [W-1:0] limit;
  logic         last;

  assign limit = high_q ? hcnt_i : lcnt_i;
  assign last  = (cnt_q == limit - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      high_q <= ~high_q;
    end else begin
      cnt_q  <= cnt_q + W'(1);
    end
  end

  assign drive_low_o = en_i & ~high_q;
  assign fall_o      = en_i & ~high_q & (cnt_q == '0);

  // R7
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && !high_q);

  // R5 R6
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !last) |=> (high_q == $past(high_q)));

  // R5 R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < limit));

  // R8
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];

  // R9
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q[0]) |=> $rose(sync_q[1]));
endmodule

// File: rtl/scl_ss_gen.sv
module scl_ss_gen
  import scl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  input  logic              scl_i,
  output logic              scl_drive_low_o,
  output logic              scl_fall_o
);
  logic             run_q;
  logic             we_ctrl, we_hcnt, we_lcnt;
  logic [CNT_W-1:0] hcnt, lcnt;
  logic             line_s;

  assign we_ctrl = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign we_hcnt = reg_we_i && (reg_addr_i == ADDR_HCNT);
  assign we_lcnt = reg_we_i && (reg_addr_i == ADDR_LCNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (we_ctrl) run_q <= reg_wdata_i[0];
  end

  scl_cnt_reg #(.W(CNT_W), .MIN(CNT_MIN), .RST(HCNT_RST)) u_hcnt (
    .clk_i, .rst_ni, .we_i(we_hcnt), .lock_i(run_q),
    .wdata_i(reg_wdata_i), .q_o(hcnt)
  );

  scl_cnt_reg #(.W(CNT_W), .MIN(CNT_MIN), .RST(LCNT_RST)) u_lcnt (
    .clk_i, .rst_ni, .we_i(we_lcnt), .lock_i(run_q),
    .wdata_i(reg_wdata_i), .q_o(lcnt)
  );

  scl_phase_timer #(.W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .en_i(run_q), .hcnt_i(hcnt), .lcnt_i(lcnt),
    .drive_low_o(scl_drive_low_o), .fall_o(scl_fall_o)
  );

  scl_line_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(scl_i), .q_o(line_s)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {{(CNT_W-1){1'b0}}, run_q};
      ADDR_HCNT: reg_rdata_o = hcnt;
      ADDR_LCNT: reg_rdata_o = lcnt;
      default:   reg_rdata_o = {{(CNT_W-1){1'b0}}, line_s};
    endcase
  end

  // R7
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_ctrl && !reg_wdata_i[0]) |=> !scl_drive_low_o);
endmodule

// File: tb/scl_ss_gen_tb.sv
module scl_ss_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        drive_low, fall;
  logic        ext_low = 1'b0;
  logic        line;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  assign line = ~(drive_low | ext_low);

  scl_ss_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .scl_i(line),
    .scl_drive_low_o(drive_low), .scl_fall_o(fall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 hcnt", v, 16'h0190);
    rd(2'd2, v); chk("R1 lcnt", v, 16'h0310);
    chk("R1 scl released", drive_low, 0);
    rd(2'd3, v); chk("R9 line after reset", v, 1);
  endtask

  task automatic t_clamp();
    logic [15:0] v;
    wr(2'd2, 16'd3);  rd(2'd2, v); chk("R4 low 3->8", v, 8);
    wr(2'd2, 16'd0);  rd(2'd2, v); chk("R4 low 0->8", v, 8);
    wr(2'd1, 16'd7);  rd(2'd1, v); chk("R4 high 7->8", v, 8);
    wr(2'd1, 16'd8);  rd(2'd1, v); chk("R4 high 8", v, 8);
    wr(2'd2, 16'd9);  rd(2'd2, v); chk("R4 low 9", v, 9);
    wr(2'd0, 16'hfffe); rd(2'd0, v); chk("R2 ctrl bit0 only", v, 0);
  endtask

  // expects run bit just written to 1 (returned at negedge)
  task automatic t_measure(input int lo, input int hi, input string tag);
    int n;
    chk({"R7 low at start ", tag}, drive_low, 1);
    chk({"R8 strobe at first low ", tag}, fall, 1);
    for (int p = 0; p < 2; p++) begin
      n = 0;
      while (drive_low && n < 2000) begin
        if (n > 0 && fall) chk({"R8 strobe only first ", tag}, fall, 0);
        n++; @(negedge clk);
      end
      chk({"R5 low length ", tag}, n, lo);
      n = 0;
      while (!drive_low && n < 2000) begin
        if (fall) chk({"R8 no strobe in high ", tag}, fall, 0);
        n++; @(negedge clk);
      end
      chk({"R6 high length ", tag}, n, hi);
      chk({"R8 strobe at fall ", tag}, fall, 1);
    end
  endtask

  task automatic t_wave(input logic [15:0] lo, input logic [15:0] hi, input string tag);
    wr(2'd2, lo); wr(2'd1, hi);
    wr(2'd0, 16'd1);
    t_measure(int'(lo), int'(hi), tag);
    wr(2'd0, 16'd0);
    chk({"R7 released on stop ", tag}, drive_low, 0);
    chk({"R8 no strobe stopped ", tag}, fall, 0);
  endtask

  task automatic t_lock();
    logic [15:0] v;
    wr(2'd2, 16'd10); wr(2'd1, 16'd12);
    wr(2'd0, 16'd1);
    wr(2'd2, 16'h0020); wr(2'd1, 16'd3);
    rd(2'd2, v); chk("R3 low locked", v, 10);
    rd(2'd1, v); chk("R3 high locked", v, 12);
    rd(2'd0, v); chk("R2 ctrl reads run", v, 1);
    wr(2'd0, 16'd0);
    rd(2'd0, v); chk("R3 ctrl writable while running", v, 0);
    repeat (5) @(negedge clk);
    chk("R7 idle stays released", drive_low, 0);
    wr(2'd2, 16'd11); rd(2'd2, v); chk("R3 unlocked after stop", v, 11);
  endtask

  task automatic t_line();
    logic [15:0] v;
    addr = 2'd3;
    @(negedge clk); ext_low = 1'b1;
    @(negedge clk); #1 chk("R9 one cycle not yet", rdata, 1);
    @(negedge clk); #1 chk("R9 two cycles seen", rdata, 0);
    ext_low = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd3, v); chk("R9 released", v, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clamp();
    t_wave(16'd10, 16'd13, "10/13");
    t_wave(16'd8, 16'd8, "min");
    t_wave(16'd21, 16'd9, "21/9");
    t_lock();
    t_line();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule